// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Qualifier

This block sits at the digital front of a frequency-synthesis loop. A fast oscillator signal and an external reference both arrive on pins and are sampled on one system clock. The oscillator is brought down to the reference rate by an integer divider. The rising edges of the divided signal are then compared with the rising edges of the reference. Two steering outputs result: `up` asks a later charge pump to speed the oscillator up, and `down` asks it to slow down. Each pulse lasts as many system clocks as the edges are apart.

The comparison senses frequency as well as phase. When one input runs faster than the other, the steering output for that input stays active across cycles, so the loop is always pushed the right way and never settles on a harmonic. A qualifier watches the width of each comparison pulse. It raises `locked` after a run of consecutive comparisons whose pulse fits a small tolerance. It drops `locked` as soon as any pulse grows past that tolerance.

Top module: `phase_freq_detector`

## Requirements
- R1: While `rst_n` is low at a clock edge, `up`, `down`, `locked` and `div_out` are all 0 after that edge.
- R2: `div_out` toggles on every DIV_HALF-th detected oscillator rising edge. Its period is therefore 2*DIV_HALF oscillator periods, and its rising edges are evenly spaced.
- R3: When the divided rising edge comes N system clocks before the reference rising edge, `down` pulses high for exactly N clocks and `up` stays 0.
- R4: When the reference rising edge comes N system clocks before the divided rising edge, `up` pulses high for exactly N clocks and `down` stays 0.
- R5: When both rising edges are detected on the same system clock, neither `up` nor `down` is asserted for that comparison.
- R6: When the reference runs at a higher frequency than the divided oscillator, only `up` is ever asserted. When it runs at a lower frequency, only `down` is asserted. In both cases `locked` stays 0.
- R7: `locked` rises only after LOCK_WINDOW consecutive in-tolerance comparisons. With aligned inputs it is still 0 after 9 reference periods and is 1 after 10 (default window 10).
- R8: A comparison is in tolerance when its pulse lasts no more than PHASE_TOL clocks (default 2). An edge offset of 2 clocks reaches lock. An offset of 3 never does.
- R9: On the clock after a steering pulse has been high for more than PHASE_TOL clocks, `locked` is 0 and the run of good comparisons restarts.
- R10: `up` and `down` are never high on the same clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the oscillator |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_in | input | 1 | Oscillator signal to be divided, asynchronous |
| ref_in | input | 1 | Reference signal at the divided rate, asynchronous |
| div_out | output | 1 | Divided oscillator square wave |
| up | output | 1 | Steering pulse: reference edge leads |
| down | output | 1 | Steering pulse: divided edge leads |
| locked | output | 1 | High after a full run of in-tolerance comparisons |

## Verification
A detector flop that is stuck set, or that misses its clear, leaves `up` or `down` high past the next edge. This shows on the pins within one reference period as a pulse of the wrong width or the wrong polarity. A wrong count in the divider moves the spacing between `div_out` rising edges at the next wrap. It also turns aligned inputs into steady one-sided steering pulses. A fault in the pulse-age or run counter moves the rising edge of `locked` by whole reference periods, or lets it survive a wide pulse. Watching `locked` at the ninth and tenth period and after a phase step exposes this.

// File: rtl/pfd_pkg.sv
// Package: shared types and helpers for the phase-frequency detector.
// Assumes: nothing beyond IEEE 1800-2017 constant functions.
package pfd_pkg;

    // One system-clock edge event from each compared input.
    typedef struct packed {
        logic ref_rise;
        logic div_rise;
    } pfd_edges_t;

    // Counter width for values 0..n-1, never below one bit.
    function automatic int unsigned width_for(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/pfd_edge_sync.sv
// Module: pfd_edge_sync
// Brings an asynchronous pin into the clock domain through a chain of
// STAGES flops. It then flags each rising edge as a single-clock pulse.
// Assumes: STAGES >= 2, and the input stays high and low for at least one
// clock each, so that every level change is sampled.
module pfd_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);

    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Synchronizer chain, one flop per stage.
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[i] <= 1'b0;
                else        sync_q[i] <= async_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[i] <= 1'b0;
                else        sync_q[i] <= sync_q[i-1];
            end
        end
    end

    // Hold the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[STAGES-1];
    end

    // Rising edge: high now, low on the previous clock.
    always_comb rise = sync_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/pfd_divider.sv
// Module: pfd_divider
// Counts oscillator rising edges from 0 to HALF_COUNT-1 and wraps. Each
// wrap toggles the divided output, which divides by 2*HALF_COUNT. The
// divided rising edge is flagged in the same clock as the wrap that
// produces it, so it keeps the same latency as the reference path.
// Assumes: osc_rise is a single-clock pulse.
module pfd_divider #(
    parameter int unsigned HALF_COUNT = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_rise,
    output logic div_out,
    output logic div_rise
);

    localparam int unsigned CNT_W = pfd_pkg::width_for(HALF_COUNT);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_COUNT - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             div_q;
    logic             wrap;

    // Terminal count reached on this oscillator edge.
    always_comb begin
        wrap     = osc_rise && (cnt_q == LAST);
        div_rise = wrap && !div_q;
        div_out  = div_q;
    end

    // Edge counter and output toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            div_q <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            div_q <= ~div_q;
        end else if (osc_rise) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/pfd_phase_core.sv
// Module: pfd_phase_core
// Two-flop detector that senses both phase and frequency. A reference edge
// sets the up flop and a divided edge sets the down flop. When both would
// be set, both clear together, so coincident edges give no pulse at all.
// Assumes: edge inputs are single-clock pulses.
module pfd_phase_core (
    input  logic               clk,
    input  logic               rst_n,
    input  pfd_pkg::pfd_edges_t edges,
    output logic               up,
    output logic               down
);

    logic up_q, dn_q;
    logic nxt_up, nxt_dn;

    // Candidate next state before the mutual clear.
    always_comb begin
        nxt_up = up_q | edges.ref_rise;
        nxt_dn = dn_q | edges.div_rise;
        up     = up_q;
        down   = dn_q;
    end

    // Set on edges, clear both once both are seen.
    always_ff @(posedge clk) begin
        if (!rst_n || (nxt_up && nxt_dn)) begin
            up_q <= 1'b0;
            dn_q <= 1'b0;
        end else begin
            up_q <= nxt_up;
            dn_q <= nxt_dn;
        end
    end

endmodule

// File: rtl/pfd_lock_qual.sv
// Module: pfd_lock_qual
// Times each steering pulse. A comparison that closes within TOL clocks
// (or with coincident edges) counts as good. WINDOW good comparisons in a
// row raise locked. A pulse that outlives TOL clears the run and drops
// locked on the next clock.
// Assumes: up/down come from pfd_phase_core, which clears both on the
// clock a comparison closes.
module pfd_lock_qual #(
    parameter int unsigned TOL    = 2,
    parameter int unsigned WINDOW = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               up,
    input  logic               down,
    input  pfd_pkg::pfd_edges_t edges,
    output logic               locked
);

    localparam int unsigned AGE_W  = pfd_pkg::width_for(TOL + 1);
    localparam int unsigned LOCK_W = pfd_pkg::width_for(WINDOW + 1);
    localparam logic [AGE_W-1:0]  AGE_MAX  = AGE_W'(TOL);
    localparam logic [LOCK_W-1:0] WIN_FULL = LOCK_W'(WINDOW);
    localparam logic [LOCK_W-1:0] WIN_LAST = LOCK_W'(WINDOW - 1);

    logic [AGE_W-1:0]  age_q;
    logic [LOCK_W-1:0] run_q;
    logic              locked_q;
    logic              active, closing, too_long, good;

    // Classify this clock's comparison state.
    always_comb begin
        active   = up | down;
        closing  = (up & edges.div_rise) | (down & edges.ref_rise) |
                   (!active & edges.ref_rise & edges.div_rise);
        too_long = active && (age_q >= AGE_MAX);
        good     = closing && !too_long;
        locked   = locked_q;
    end

    // Age of the open pulse, saturating at the tolerance.
    always_ff @(posedge clk) begin
        if (!rst_n || !active || closing) age_q <= '0;
        else if (age_q < AGE_MAX)         age_q <= age_q + AGE_W'(1);
    end

    // Consecutive good comparisons and the lock flag.
    always_ff @(posedge clk) begin
        if (!rst_n || too_long) begin
            run_q    <= '0;
            locked_q <= 1'b0;
        end else if (good) begin
            if (run_q < WIN_FULL) run_q <= run_q + LOCK_W'(1);
            if (run_q >= WIN_LAST) locked_q <= 1'b1;
        end
    end

endmodule

// File: rtl/phase_freq_detector.sv
// Module: phase_freq_detector (top)
// Synchronizes the oscillator and reference pins, divides the oscillator
// down to the reference rate, and compares rising edges to steer the loop.
// It also qualifies lock over consecutive reference periods.
// Assumes: clk is fast enough that each input level lasts at least one
// clock, and the reference rate is close to osc rate / (2*DIV_HALF).
module phase_freq_detector #(
    parameter int unsigned DIV_HALF    = 500,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned PHASE_TOL   = 2,
    parameter int unsigned LOCK_WINDOW = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_in,
    input  logic ref_in,
    output logic div_out,
    output logic up,
    output logic down,
    output logic locked
);

    logic                osc_rise;
    logic                ref_rise;
    logic                div_rise;
    pfd_pkg::pfd_edges_t edges;

    pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_osc_sync (
        .clk(clk), .rst_n(rst_n), .async_in(osc_in), .rise(osc_rise)
    );

    pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
        .clk(clk), .rst_n(rst_n), .async_in(ref_in), .rise(ref_rise)
    );

    pfd_divider #(.HALF_COUNT(DIV_HALF)) u_div (
        .clk(clk), .rst_n(rst_n), .osc_rise(osc_rise),
        .div_out(div_out), .div_rise(div_rise)
    );

    // Bundle the two compared edge events.
    always_comb begin
        edges.ref_rise = ref_rise;
        edges.div_rise = div_rise;
    end

    pfd_phase_core u_core (
        .clk(clk), .rst_n(rst_n), .edges(edges), .up(up), .down(down)
    );

    pfd_lock_qual #(.TOL(PHASE_TOL), .WINDOW(LOCK_WINDOW)) u_lock (
        .clk(clk), .rst_n(rst_n), .up(up), .down(down),
        .edges(edges), .locked(locked)
    );

endmodule

// File: rtl/pfd_checker.sv
// Module: pfd_checker
// Port-level properties of phase_freq_detector, attached by bind below.
// Assumes: observation only; its pulse-length counter watches the pins.
module pfd_checker #(
    parameter int unsigned TOL = 2
) (
    input logic clk,
    input logic rst_n,
    input logic div_out,
    input logic up,
    input logic down,
    input logic locked
);

    int unsigned obs_len_q;

    // Consecutive earlier clocks with a steering pulse high.
    always_ff @(posedge clk) begin
        if (!rst_n || !(up || down)) obs_len_q <= 0;
        else if (obs_len_q < 1000)   obs_len_q <= obs_len_q + 1;
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!up && !down && !locked && !div_out));

    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(up && down));

    a_r9_wide_pulse_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
        ((up || down) && obs_len_q >= TOL) |=> !locked);

    a_r2_div_min_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (div_out != $past(div_out)) |=> $stable(div_out));

endmodule

bind phase_freq_detector pfd_checker #(.TOL(PHASE_TOL)) u_pfd_checker (
    .clk(clk), .rst_n(rst_n), .div_out(div_out),
    .up(up), .down(down), .locked(locked)
);

// File: tb/test_phase_freq_detector.sv
// Directed bench for phase_freq_detector with a short divide ratio.
module test_phase_freq_detector;

    localparam int DIV_HALF = 5;
    localparam int TOL      = 2;
    localparam int OSC_PER  = 4;
    localparam int REF_PER  = 2 * DIV_HALF * OSC_PER;   // 40 clocks
    localparam int DIV_T0   = (DIV_HALF - 1) * OSC_PER; // first divided edge
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic osc_in = 1'b0;
    logic ref_in = 1'b0;
    logic div_out, up, down, locked;

    phase_freq_detector #(.DIV_HALF(DIV_HALF), .PHASE_TOL(TOL), .LOCK_WINDOW(10))
        i_phase_freq_detector (
        .clk(clk), .rst_n(rst_n), .osc_in(osc_in), .ref_in(ref_in),
        .div_out(div_out), .up(up), .down(down), .locked(locked)
    );

    always #10 clk = ~clk;

    int checks = 0, failures = 0, cyc = 0;
    int t = 0, ref_start = 0, ref_per = REF_PER;
    int up_run, dn_run, up_cnt, dn_cnt, up_min, up_max, dn_min, dn_max;
    int both_cnt = 0, div_rises, div_last, div_imin, div_imax;
    logic div_prev = 1'b0;

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            checks++; failures++;
            $display("FAIL watchdog all: got %0d cycles expected fewer", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_stats();
        up_cnt = 0; dn_cnt = 0; up_min = 9999; up_max = 0;
        dn_min = 9999; dn_max = 0; div_rises = 0; div_last = -1;
        div_imin = 9999; div_imax = 0;
    endtask

    // One system clock: observe outputs, then drive next input levels.
    task automatic tick();
        @(negedge clk);
        if (up && down) both_cnt++;
        if (up) up_run++;
        else if (up_run > 0) begin
            up_cnt++;
            if (up_run < up_min) up_min = up_run;
            if (up_run > up_max) up_max = up_run;
            up_run = 0;
        end
        if (down) dn_run++;
        else if (dn_run > 0) begin
            dn_cnt++;
            if (dn_run < dn_min) dn_min = dn_run;
            if (dn_run > dn_max) dn_max = dn_run;
            dn_run = 0;
        end
        if (div_out && !div_prev) begin
            if (div_last >= 0) begin
                if (t - div_last < div_imin) div_imin = t - div_last;
                if (t - div_last > div_imax) div_imax = t - div_last;
            end
            div_last = t;
            div_rises++;
        end
        div_prev = div_out;
        t++;
        osc_in = (t % OSC_PER) < (OSC_PER / 2);
        ref_in = (t >= ref_start) && (((t - ref_start) % ref_per) < ref_per / 2);
    endtask

    task automatic run_periods(input int n);
        repeat (n * REF_PER) tick();
    endtask

    // Reset with quiet inputs; offset is the reference lag behind the divided edge.
    task automatic do_reset(input int offset, input int period);
        @(negedge clk);
        rst_n = 1'b0; osc_in = 1'b0; ref_in = 1'b0;
        repeat (4) @(negedge clk);
        check("R1 up after reset", int'(up), 0);
        check("R1 down after reset", int'(down), 0);
        check("R1 locked after reset", int'(locked), 0);
        check("R1 div_out after reset", int'(div_out), 0);
        ref_per = period;
        ref_start = DIV_T0 + offset;
        t = 0; up_run = 0; dn_run = 0; div_prev = 1'b0;
        clear_stats();
        rst_n = 1'b1;
        osc_in = 1'b1;
        ref_in = (ref_start == 0);
    endtask

    task automatic t_divider();
        do_reset(0, REF_PER);
        run_periods(20);
        check("R2 div_out rising edges", div_rises, 20);
        check("R2 min spacing", div_imin, REF_PER);
        check("R2 max spacing", div_imax, REF_PER);
        check("R5 coincident: up pulses", up_cnt, 0);
        check("R5 coincident: down pulses", dn_cnt, 0);
    endtask

    task automatic t_lock_timing();
        do_reset(0, REF_PER);
        run_periods(9);
        check("R7 locked after 9 periods", int'(locked), 0);
        run_periods(1);
        check("R7 locked after 10 periods", int'(locked), 1);
    endtask

    task automatic t_lead(input int off);
        int w;
        w = (off < 0) ? -off : off;
        do_reset(off, REF_PER);
        run_periods(20);
        if (off > 0) begin
            check("R3 up pulses when divided leads", up_cnt, 0);
            check("R3 down width min", dn_min, w);
            check("R3 down width max", dn_max, w);
        end else begin
            check("R4 down pulses when reference leads", dn_cnt, 0);
            check("R4 up width min", up_min, w);
            check("R4 up width max", up_max, w);
        end
        check("R8 lock vs tolerance", int'(locked), (w <= TOL) ? 1 : 0);
    endtask

    task automatic t_freq(input int period, input bit ref_fast);
        do_reset(0, period);
        run_periods(15);
        if (ref_fast) begin
            check("R6 fast ref: down pulses", dn_cnt, 0);
            check("R6 fast ref: up seen", int'(up_cnt > 0), 1);
        end else begin
            check("R6 slow ref: up pulses", up_cnt, 0);
            check("R6 slow ref: down seen", int'(dn_cnt > 0), 1);
        end
        check("R6 no lock on frequency error", int'(locked), 0);
    endtask

    task automatic t_drop();
        do_reset(0, REF_PER);
        run_periods(12);
        check("R9 locked before phase step", int'(locked), 1);
        ref_start = ref_start + 5;
        run_periods(1);
        check("R9 unlocked after phase step", int'(locked), 0);
        clear_stats();
        run_periods(10);
        check("R9 stays unlocked", int'(locked), 0);
        check("R9 down width after step", dn_max, 5);
        check("R9 up pulses after step", up_cnt, 0);
    endtask

    initial begin
        t_divider();
        t_lock_timing();
        t_lead(2);
        t_lead(-2);
        t_lead(3);
        t_lead(-4);
        t_freq(30, 1'b1);
        t_freq(50, 1'b0);
        t_drop();
        check("R10 up and down together", both_cnt, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule